// File: doc/BRIEF.md
# Programmable Interrupt Controller Core

This block gathers eight interrupt request lines and presents a single interrupt signal to a processor. Software sets it up through a small register port of two addresses, chosen by one select bit. First comes a fixed sequence of setup words that programs the vector base and the cascade arrangement. After that, the odd address holds the per-line mask and the even address accepts commands. Request lines are edge-triggered and are latched until they are serviced. Line 0 has the highest priority and line 7 the lowest.

When the processor acknowledges the interrupt, the block places the winning line's vector (base plus line number) on the vector output in that same cycle. It also moves the line from pending to in-service. Lines of equal or lower rank are then held back until software sends a non-specific end-of-interrupt command. The processor's own interrupt-enable flag lives outside this block.

Top module: `pic_core`

## Requirements
- R1: After reset, int_out and vec_out are 0, every line is masked and the block is uninitialized.
- R2: Odd-address writes made before any setup start word is seen have no effect; in particular they do not load the mask.
- R3: An even-address write with data bit 4 set is a setup start word. It is accepted at any time and restarts the sequence. It clears all pending and in-service lines but leaves the mask unchanged. Its bit 0 = 1 announces a fourth word and its bit 1 = 1 selects single mode. While setup is incomplete, int_out stays 0 and line edges are not latched.
- R4: The second setup word (odd address) is the vector base B. Line n is reported as vector (B + n) mod 256.
- R5: In cascade mode (start bit 1 = 0), the odd write after the base is the cascade word. It is followed by the fourth word when one was announced. Only the odd write after these becomes the mask.
- R6: Once set up, every odd write loads the mask from wr_data[7:0], where bit n = 1 blocks line n. A masked line's edge stays latched and is raised once the line is unmasked.
- R7: A request is latched only on a rising edge of its line. A line held high after being serviced does not request again.
- R8: Priority is fixed, with line 0 highest. int_out is 1 exactly when the block is set up and some unmasked pending line outranks every in-service line.
- R9: An int_ack cycle with int_out high drives the winning vector on vec_out in that same cycle and moves that line from pending to in-service. An int_ack with int_out low drives 0 and changes nothing. vec_out is 0 whenever int_ack is low.
- R10: Writing 0x20 to the even address once set up clears the highest-priority in-service line. Other even writes with bit 4 clear are ignored.
- R11: In single mode the cascade word is skipped. If no fourth word was announced, the odd write right after the base loads the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register address: 0 even, 1 odd |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| irq_in | input | 8 | Edge-triggered request lines |
| int_ack | input | 1 | Interrupt acknowledge from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector number, valid during an acknowledge cycle |

## Verification
A setup sequencer that has slipped by one word shows up at the ports directly. Either a line that should be blocked raises int_out, or a later acknowledge returns a vector from the wrong base, and both appear within a few cycles of the first request. A lost or stale in-service bit shows up as int_out staying low after an end-of-interrupt command, or rising for a lower-ranked line too early. The bench checks int_out in the cycle after every write and every request edge, and checks the vector on every acknowledge.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [2:0] {
        S_UNINIT,
        S_BASE,
        S_CASC,
        S_MODE,
        S_READY
    } seq_e;

    localparam logic [7:0] EOI_CMD   = 8'h20;
    localparam int         START_BIT = 4;
    localparam int         NEED4_BIT = 0;
    localparam int         SINGLE_BIT = 1;
endpackage

// File: rtl/pic_edge_det.sv
module pic_edge_det #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    assign rise = lines & ~prev_q;
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pic_core.sv
module pic_core #(
    parameter int N_IRQ = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_en,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             int_ack,
    output logic             int_out,
    output logic [DW-1:0]    vec_out
);
    import pic_pkg::*;

    localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    typedef struct packed {
        seq_e             seq;
        logic             need4;
        logic             single;
        logic [DW-1:0]    base;
        logic [DW-1:0]    casc;
        logic [DW-1:0]    mode;
        logic [N_IRQ-1:0] imr;
        logic [N_IRQ-1:0] irr;
        logic [N_IRQ-1:0] isr;
    } pic_st_t;

    pic_st_t st_d, st_q;

    logic [N_IRQ-1:0] rise;
    logic             req_vld, isr_vld;
    logic [IW-1:0]    req_idx, isr_idx;

    pic_edge_det #(.N(N_IRQ)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (irq_in),
        .rise  (rise)
    );

    pic_prio_enc #(.N(N_IRQ)) u_req_prio (
        .req   (st_q.irr & ~st_q.imr),
        .valid (req_vld),
        .idx   (req_idx)
    );

    pic_prio_enc #(.N(N_IRQ)) u_isr_prio (
        .req   (st_q.isr),
        .valid (isr_vld),
        .idx   (isr_idx)
    );

    logic ready, odd_wr, even_wr, start_wr, eoi_wr, ack_go;

    always_comb begin
        st_d     = st_q;
        vec_out  = '0;
        ready    = (st_q.seq == S_READY);
        odd_wr   = wr_en & reg_sel;
        even_wr  = wr_en & ~reg_sel;
        start_wr = even_wr & wr_data[START_BIT];
        eoi_wr   = even_wr & ready & (wr_data == DW'(EOI_CMD));
        int_out  = ready & req_vld & (!isr_vld || (req_idx < isr_idx));
        ack_go   = int_ack & int_out;

        if (eoi_wr && isr_vld)
            st_d.isr[isr_idx] = 1'b0;

        if (ack_go) begin
            st_d.irr[req_idx] = 1'b0;
            st_d.isr[req_idx] = 1'b1;
            vec_out = st_q.base + DW'(req_idx);
        end

        if (ready)
            st_d.irr = st_d.irr | rise;

        if (start_wr) begin
            st_d.seq    = S_BASE;
            st_d.need4  = wr_data[NEED4_BIT];
            st_d.single = wr_data[SINGLE_BIT];
            st_d.irr    = '0;
            st_d.isr    = '0;
        end else if (odd_wr) begin
            unique case (st_q.seq)
                S_BASE: begin
                    st_d.base = wr_data;
                    if (!st_q.single) st_d.seq = S_CASC;
                    else if (st_q.need4) st_d.seq = S_MODE;
                    else st_d.seq = S_READY;
                end
                S_CASC: begin
                    st_d.casc = wr_data;
                    st_d.seq  = st_q.need4 ? S_MODE : S_READY;
                end
                S_MODE: begin
                    st_d.mode = wr_data;
                    st_d.seq  = S_READY;
                end
                S_READY: st_d.imr = wr_data[N_IRQ-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.seq    <= S_UNINIT;
            st_q.imr    <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk #(
    parameter int N_IRQ = 8,
    parameter int DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_sel,
    input logic [DW-1:0]    wr_data,
    input logic             wr_en,
    input logic             int_ack,
    input logic             int_out,
    input logic [DW-1:0]    vec_out,
    input logic             ready,
    input logic [N_IRQ-1:0] imr,
    input logic [N_IRQ-1:0] irr,
    input logic [N_IRQ-1:0] isr
);
    a_r2_early_odd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && !ready) |=> $stable(imr));

    a_r3_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_out);

    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_en && reg_sel) |=> (imr == $past(wr_data[N_IRQ-1:0])));

    a_r8_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (|(irr & ~imr)));

    a_r9_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !int_ack |-> (vec_out == '0));

    a_r9_ack_to_service: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out && !(wr_en && !reg_sel))
        |=> ($countones(isr) == $countones($past(isr)) + 1));

    a_r10_eoi_frees_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_en && !reg_sel && wr_data == DW'(8'h20) && (|isr) && !int_ack)
        |=> ($countones(isr) + 1 == $countones($past(isr))));
endmodule

bind pic_core pic_core_chk #(.N_IRQ(N_IRQ), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_sel (reg_sel),
    .wr_data (wr_data),
    .wr_en   (wr_en),
    .int_ack (int_ack),
    .int_out (int_out),
    .vec_out (vec_out),
    .ready   (st_q.seq == pic_pkg::S_READY),
    .imr     (st_q.imr),
    .irr     (st_q.irr),
    .isr     (st_q.isr)
);

// File: tb/tb_pic_core.sv
`timescale 1ns/1ps
module tb_pic_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic [7:0] irq_in = '0;
    logic       int_ack = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    pic_core dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_sel (reg_sel),
        .wr_data (wr_data),
        .wr_en   (wr_en),
        .irq_in  (irq_in),
        .int_ack (int_ack),
        .int_out (int_out),
        .vec_out (vec_out)
    );

    localparam logic [3:0] OP_WE = 4'd0, OP_WO = 4'd1, OP_PULSE = 4'd2,
                           OP_INT = 4'd3, OP_ACK = 4'd4;

    // entry: {op, arg, expected, requirement number}
    localparam int NT = 23;
    localparam logic [23:0] TBL [NT] = '{
        {OP_WE,    8'h11, 8'h00, 4'd5},  // R5 start word, cascade, fourth word follows
        {OP_WO,    8'h20, 8'h00, 4'd4},  // R4 base 0x20
        {OP_WO,    8'h04, 8'h00, 4'd5},  // R5 cascade word
        {OP_WO,    8'h01, 8'h00, 4'd5},  // R5 fourth word
        {OP_INT,   8'h00, 8'h00, 4'd3},  // R3 nothing pending
        {OP_PULSE, 8'd0,  8'h00, 4'd6},  // R6 edge on masked line 0
        {OP_INT,   8'h00, 8'h00, 4'd6},  // R6 still masked
        {OP_WO,    8'hFE, 8'h00, 4'd6},  // R6 unmask line 0 only
        {OP_INT,   8'h00, 8'h01, 4'd6},  // R6 latched edge now raised
        {OP_ACK,   8'h00, 8'h20, 4'd9},  // R9 vector 0x20
        {OP_INT,   8'h00, 8'h00, 4'd9},  // R9 moved to service
        {OP_WO,    8'h00, 8'h00, 4'd6},  // R6 unmask all
        {OP_PULSE, 8'd5,  8'h00, 4'd8},  // R8 line 5 pending
        {OP_INT,   8'h00, 8'h00, 4'd8},  // R8 blocked by line 0 in service
        {OP_WE,    8'h20, 8'h00, 4'd10}, // R10 end of interrupt
        {OP_INT,   8'h00, 8'h01, 4'd10}, // R10 line 5 released
        {OP_PULSE, 8'd2,  8'h00, 4'd8},  // R8 line 2 joins
        {OP_ACK,   8'h00, 8'h22, 4'd8},  // R8 line 2 wins over 5
        {OP_INT,   8'h00, 8'h00, 4'd8},  // R8 line 5 waits
        {OP_WE,    8'h20, 8'h00, 4'd10}, // R10
        {OP_ACK,   8'h00, 8'h25, 4'd4},  // R4 vector 0x25
        {OP_WE,    8'h20, 8'h00, 4'd10}, // R10
        {OP_INT,   8'h00, 8'h00, 4'd8}   // R8 idle
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; int_ack = 1'b0; irq_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int line);
        @(negedge clk);
        irq_in[line] = 1'b1;
        @(negedge clk);
        irq_in[line] = 1'b0;
    endtask

    task automatic ack(input int req, input logic [7:0] exp);
        @(negedge clk);
        int_ack = 1'b1;
        #1 check(req, vec_out, exp);
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic chk_int(input int req, input logic exp);
        @(negedge clk);
        #1 check(req, {7'd0, int_out}, {7'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset outputs
        #1 check(1, {7'd0, int_out}, 8'h00);
        check(1, vec_out, 8'h00);

        for (int i = 0; i < NT; i++) begin
            logic [3:0] op;
            logic [7:0] arg, exp;
            int req;
            op  = TBL[i][23:20];
            arg = TBL[i][19:12];
            exp = TBL[i][11:4];
            req = int'(TBL[i][3:0]);
            case (op)
                OP_WE:    wr(1'b0, arg);
                OP_WO:    wr(1'b1, arg);
                OP_PULSE: pulse(int'(arg));
                OP_INT:   chk_int(req, exp[0]);
                OP_ACK:   ack(req, exp);
                default:  ;
            endcase
        end

        // R2 and R1: early odd write must not unmask
        do_reset();
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        pulse(3);
        chk_int(2, 1'b0);
        wr(1'b1, 8'hF7);
        chk_int(2, 1'b1);

        // R9 acknowledge with nothing raised
        do_reset();
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        wr(1'b1, 8'h00);
        ack(9, 8'h00);
        chk_int(9, 1'b0);

        // R11 single mode, no fourth word: next odd write is the mask
        do_reset();
        wr(1'b0, 8'h12); wr(1'b1, 8'h28); wr(1'b1, 8'h00);
        pulse(0);
        chk_int(11, 1'b1);
        ack(11, 8'h28);
        // R10 an unrelated even write leaves service alone
        pulse(5);
        chk_int(10, 1'b0);
        wr(1'b0, 8'h0A);
        chk_int(10, 1'b0);
        wr(1'b0, 8'h20);
        chk_int(10, 1'b1);
        ack(10, 8'h2D);
        wr(1'b0, 8'h20);

        // R3 restart mid-use clears pending, edges ignored while setting up
        wr(1'b1, 8'hFF);
        pulse(4);
        wr(1'b0, 8'h13);
        pulse(6);
        chk_int(3, 1'b0);
        wr(1'b1, 8'h40); wr(1'b1, 8'h01);
        wr(1'b1, 8'h00);
        chk_int(3, 1'b0);
        pulse(1);
        ack(3, 8'h41);
        wr(1'b0, 8'h20);

        // R4 base wrap and R7 held level
        wr(1'b0, 8'h12); wr(1'b1, 8'hFC); wr(1'b1, 8'h00);
        @(negedge clk); irq_in[6] = 1'b1;
        ack(4, 8'h02);
        wr(1'b0, 8'h20);
        chk_int(7, 1'b0);
        @(negedge clk); irq_in[6] = 1'b0;
        @(negedge clk); irq_in[6] = 1'b1;
        chk_int(7, 1'b1);
        ack(7, 8'h02);
        irq_in[6] = 1'b0;
        wr(1'b0, 8'h20);
        chk_int(7, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule